// File: doc/BRIEF.md
# Fetch Target Buffer

This block predicts the address of the next instruction fetch. In every cycle the fetch stage gives it the current program counter. The block reads one slot of a direct-mapped table, selected by the low-order word-address bits of that counter, and compares the stored tag with the upper address bits. If the slot is valid and the tag matches, the block reports a hit and returns the recorded branch destination as the next fetch address. In every other case it reports a miss and returns the sequential address (PC + 4). A miss therefore behaves as a not-taken prediction. A miss can come from a branch seen for the first time, from a table too small for the working set, or from two branches that share a slot.

A second port records branch results from later in the pipeline. Only a resolved branch that was taken writes the table. It fills or overwrites its slot with a valid tag and destination. A branch that was not taken leaves every slot as it was. The block gives no direction prediction. It answers only where a branch goes if it is taken.

The lookup path is combinational from the stored state. A write becomes visible at the next clock edge, so a lookup in the same cycle as a write to the same slot still sees the old slot contents.

Top module: `fetch_target_buf`

## Requirements
- R1: After reset is asserted, every slot is invalid, and every lookup misses until a taken branch is recorded.
- R2: On a miss, `lk_hit` is 0 and `lk_next_pc` equals `lk_pc + 4` modulo 2^32, so 0xFFFFFFFC gives 0x00000000.
- R3: The cycle after a taken resolve (`rs_valid`=1, `rs_taken`=1) of address P with destination T, a lookup of P gives `lk_hit`=1 and `lk_next_pc`=T.
- R4: A resolve with `rs_taken`=0 changes no slot. An absent branch stays absent, and a recorded destination stays unchanged.
- R5: Slot selection uses PC bits [7:2] and the tag is PC bits [31:8]. PC bits [1:0] play no part in matching. An address with the same bits [7:2] and different bits [31:8] misses.
- R6: A taken resolve whose slot already holds another branch replaces that entry. The earlier branch then misses. A repeat taken resolve of the same branch with a new destination replaces the destination.
- R7: When a write and a lookup select the same slot in one cycle, the lookup returns the slot contents from before the write. The new contents appear from the next cycle.
- R8: While `rs_valid` is 0, no slot changes, whatever `rs_taken`, `rs_pc` and `rs_target` hold.
- R9: All 64 slots hold entries independently. After each slot has been filled, every filled address hits with its own destination.
- R10: The lookup result is valid in the same cycle that `lk_pc` is applied, with no register between `lk_pc` and the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; table writes happen on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; invalidates all slots |
| lk_pc | input | 32 | Fetch address to look up |
| lk_hit | output | 1 | Valid slot with matching tag was found |
| lk_next_pc | output | 32 | Predicted next fetch address |
| rs_valid | input | 1 | A resolved branch is presented this cycle |
| rs_pc | input | 32 | Address of the resolved branch |
| rs_taken | input | 1 | Resolved branch was taken |
| rs_target | input | 32 | Actual destination of the resolved branch |

## Verification
The assertions check four behaviours on every cycle:
- The sequential fallback on any miss.
- That a cycle without a taken resolve leaves every valid bit unchanged.
- That a taken resolve leaves its slot valid and visible on the next lookup of that exact address.
- That the table is empty after reset.

Other behaviours only the bench scenarios can show, because they depend on a chosen history of writes:
- Same-slot read-during-write ordering.
- Eviction between branches that share a slot.
- Independence of all 64 slots.
- Address wrap at the top of the range.
- Re-emptying of the table by a reset in the middle of a run.

// File: rtl/ftb_pkg.sv
package ftb_pkg;

    localparam int unsigned FTB_ADDR_W     = 32;
    localparam int unsigned FTB_ENTRIES    = 64;
    localparam int unsigned FTB_INSN_BYTES = 4;

    // Classification of what a resolve-port request does to the table
    typedef enum logic [1:0] {
        UPD_IDLE = 2'd0,   // nothing presented
        UPD_SKIP = 2'd1,   // branch resolved not taken: no allocation
        UPD_FILL = 2'd2    // branch resolved taken: write slot
    } upd_kind_e;

endpackage

// File: rtl/ftb_addr_split.sv
module ftb_addr_split #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned IDX_W  = 6,
    parameter int unsigned OFS_W  = 2,
    localparam int unsigned TAG_W = ADDR_W - IDX_W - OFS_W
) (
    input  logic [ADDR_W-1:0] pc,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag
);

    // Byte offset within an instruction word never takes part in matching
    logic unused_ofs;
    assign unused_ofs = ^pc[OFS_W-1:0];

    assign idx = pc[OFS_W +: IDX_W];
    assign tag = pc[ADDR_W-1 -: TAG_W];

endmodule

// File: rtl/ftb_update_ctl.sv
module ftb_update_ctl
    import ftb_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned IDX_W  = 6,
    parameter int unsigned OFS_W  = 2,
    localparam int unsigned TAG_W = ADDR_W - IDX_W - OFS_W
) (
    input  logic              rs_valid,
    input  logic              rs_taken,
    input  logic [ADDR_W-1:0] rs_pc,
    input  logic [ADDR_W-1:0] rs_target,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [TAG_W-1:0]  wr_tag,
    output logic [ADDR_W-1:0] wr_tgt
);

    typedef struct packed {
        upd_kind_e         kind;
        logic [IDX_W-1:0]  idx;
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] tgt;
    } upd_t;

    logic [IDX_W-1:0] rs_idx;
    logic [TAG_W-1:0] rs_tag;
    upd_t             upd_d;

    ftb_addr_split #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .OFS_W  (OFS_W)
    ) rs_split_i (
        .pc  (rs_pc),
        .idx (rs_idx),
        .tag (rs_tag)
    );

    always_comb begin
        upd_d.idx = rs_idx;
        upd_d.tag = rs_tag;
        upd_d.tgt = rs_target;
        if (!rs_valid) begin
            upd_d.kind = UPD_IDLE;
        end else if (rs_taken) begin
            upd_d.kind = UPD_FILL;
        end else begin
            upd_d.kind = UPD_SKIP;
        end
    end

    assign wr_en  = (upd_d.kind == UPD_FILL);
    assign wr_idx = upd_d.idx;
    assign wr_tag = upd_d.tag;
    assign wr_tgt = upd_d.tgt;

endmodule

// File: rtl/ftb_store.sv
module ftb_store #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned ENTRIES = 64,
    parameter int unsigned TAG_W   = 24,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ADDR_W-1:0] wr_tgt,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [ADDR_W-1:0] rd_tgt
);

    typedef struct packed {
        logic              vld;
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] tgt;
    } slot_t;

    logic [ENTRIES-1:0] wr_sel;
    logic [ENTRIES-1:0] vld_vec;
    slot_t              slot_rd [ENTRIES];

    always_comb begin
        wr_sel         = '0;
        wr_sel[wr_idx] = wr_en;
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        slot_t slot_d;
        slot_t slot_q;

        always_comb begin
            slot_d = slot_q;
            if (wr_sel[g]) begin
                slot_d.vld = 1'b1;
                slot_d.tag = wr_tag;
                slot_d.tgt = wr_tgt;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else begin
                slot_q <= slot_d;
            end
        end

        assign slot_rd[g] = slot_q;
        assign vld_vec[g] = slot_q.vld;
    end

    // Read returns registered state: a same-cycle write is not forwarded
    assign rd_valid = slot_rd[rd_idx].vld;
    assign rd_tag   = slot_rd[rd_idx].tag;
    assign rd_tgt   = slot_rd[rd_idx].tgt;

    // R1: reset leaves every slot invalid
    p_reset_empty_r1: assert property (@(posedge clk)
        !rst_n |=> (vld_vec == '0));

    // R4 / R8: without a fill request no valid bit moves
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(vld_vec));

    // R3: a fill leaves its slot valid
    p_alloc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> vld_vec[$past(wr_idx)]);

endmodule

// File: rtl/ftb_select.sv
module ftb_select #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned TAG_W      = 24,
    parameter int unsigned INSN_BYTES = 4
) (
    input  logic [ADDR_W-1:0] lk_pc,
    input  logic [TAG_W-1:0]  lk_tag,
    input  logic              rd_valid,
    input  logic [TAG_W-1:0]  rd_tag,
    input  logic [ADDR_W-1:0] rd_tgt,
    output logic              hit,
    output logic [ADDR_W-1:0] next_pc
);

    typedef struct packed {
        logic              hit;
        logic [ADDR_W-1:0] nxt;
    } sel_t;

    sel_t sel_d;

    always_comb begin
        sel_d.hit = rd_valid && (rd_tag == lk_tag);
        if (sel_d.hit) begin
            sel_d.nxt = rd_tgt;
        end else begin
            sel_d.nxt = lk_pc + ADDR_W'(INSN_BYTES);
        end
    end

    assign hit     = sel_d.hit;
    assign next_pc = sel_d.nxt;

endmodule

// File: rtl/fetch_target_buf.sv
module fetch_target_buf
    import ftb_pkg::*;
#(
    parameter int unsigned ADDR_W     = FTB_ADDR_W,
    parameter int unsigned ENTRIES    = FTB_ENTRIES,
    parameter int unsigned INSN_BYTES = FTB_INSN_BYTES,
    localparam int unsigned IDX_W     = $clog2(ENTRIES),
    localparam int unsigned OFS_W     = $clog2(INSN_BYTES),
    localparam int unsigned TAG_W     = ADDR_W - IDX_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_pc,
    output logic              lk_hit,
    output logic [ADDR_W-1:0] lk_next_pc,
    input  logic              rs_valid,
    input  logic [ADDR_W-1:0] rs_pc,
    input  logic              rs_taken,
    input  logic [ADDR_W-1:0] rs_target
);

    logic [IDX_W-1:0]  lk_idx;
    logic [TAG_W-1:0]  lk_tag;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [TAG_W-1:0]  wr_tag;
    logic [ADDR_W-1:0] wr_tgt;
    logic              rd_valid;
    logic [TAG_W-1:0]  rd_tag;
    logic [ADDR_W-1:0] rd_tgt;

    ftb_addr_split #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .OFS_W  (OFS_W)
    ) lk_split_i (
        .pc  (lk_pc),
        .idx (lk_idx),
        .tag (lk_tag)
    );

    ftb_update_ctl #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .OFS_W  (OFS_W)
    ) upd_i (
        .rs_valid  (rs_valid),
        .rs_taken  (rs_taken),
        .rs_pc     (rs_pc),
        .rs_target (rs_target),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_tag    (wr_tag),
        .wr_tgt    (wr_tgt)
    );

    ftb_store #(
        .ADDR_W  (ADDR_W),
        .ENTRIES (ENTRIES),
        .TAG_W   (TAG_W)
    ) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_tag   (wr_tag),
        .wr_tgt   (wr_tgt),
        .rd_idx   (lk_idx),
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag),
        .rd_tgt   (rd_tgt)
    );

    ftb_select #(
        .ADDR_W     (ADDR_W),
        .TAG_W      (TAG_W),
        .INSN_BYTES (INSN_BYTES)
    ) sel_i (
        .lk_pc    (lk_pc),
        .lk_tag   (lk_tag),
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag),
        .rd_tgt   (rd_tgt),
        .hit      (lk_hit),
        .next_pc  (lk_next_pc)
    );

    // R2: a miss always falls back to the sequential address
    p_seq_fallback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_next_pc == lk_pc + ADDR_W'(INSN_BYTES)));

    // R3: a taken resolve is visible to a lookup of that address one cycle later
    p_write_visible_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && rs_taken) |=>
            ((lk_pc != $past(rs_pc)) || (lk_hit && (lk_next_pc == $past(rs_target)))));

endmodule

// File: tb/fetch_target_buf_tb_top.sv
module fetch_target_buf_tb_top;

    typedef struct {
        logic        hit;
        logic [31:0] nxt;
        logic [31:0] pc;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        lk_hit;
    logic [31:0] lk_next_pc;
    logic        rs_valid = 1'b0;
    logic [31:0] rs_pc = '0;
    logic        rs_taken = 1'b0;
    logic [31:0] rs_target = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    exp_t sb_q[$];

    // bench reference table, built from the requirements
    bit          m_vld [64];
    logic [23:0] m_tag [64];
    logic [31:0] m_tgt [64];

    always #2.5 clk = ~clk;

    fetch_target_buf dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_pc      (lk_pc),
        .lk_hit     (lk_hit),
        .lk_next_pc (lk_next_pc),
        .rs_valid   (rs_valid),
        .rs_pc      (rs_pc),
        .rs_taken   (rs_taken),
        .rs_target  (rs_target)
    );

    task automatic model_clear();
        for (int i = 0; i < 64; i++) begin
            m_vld[i] = 1'b0;
            m_tag[i] = '0;
            m_tgt[i] = '0;
        end
    endtask

    // Drive one cycle: a lookup plus an optional resolve; queue the expectation
    task automatic step(input logic [31:0] lpc, input logic rv, input logic rt,
                        input logic [31:0] rpc, input logic [31:0] rtgt, input string req);
        exp_t e;
        int   li;
        int   wi;
        @(posedge clk);
        #1;
        lk_pc     = lpc;
        rs_valid  = rv;
        rs_taken  = rt;
        rs_pc     = rpc;
        rs_target = rtgt;
        li    = int'(lpc[7:2]);
        e.hit = m_vld[li] && (m_tag[li] == lpc[31:8]);
        e.nxt = e.hit ? m_tgt[li] : lpc + 32'd4;
        e.pc  = lpc;
        e.req = req;
        sb_q.push_back(e);
        // table changes only after this cycle's lookup (R7)
        if (rv && rt) begin
            wi        = int'(rpc[7:2]);
            m_vld[wi] = 1'b1;
            m_tag[wi] = rpc[31:8];
            m_tgt[wi] = rtgt;
        end
    endtask

    task automatic look(input logic [31:0] lpc, input string req);
        step(lpc, 1'b0, 1'b0, 32'h0, 32'h0, req);
    endtask

    task automatic apply_reset();
        @(posedge clk);
        #1;
        rst_n    = 1'b0;
        rs_valid = 1'b0;
        model_clear();
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    // Monitor: compare every queued expectation mid-cycle
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                e = sb_q.pop_front();
                checks++;
                if (lk_hit !== e.hit || lk_next_pc !== e.nxt) begin
                    errors++;
                    $display("FAIL %s pc=%h actual hit=%b next=%h expected hit=%b next=%h",
                             e.req, e.pc, lk_hit, lk_next_pc, e.hit, e.nxt);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_clear();
        apply_reset();

        // R1: empty after reset; R2: sequential fallback, including wrap
        look(32'h0000_1040, "R1");
        look(32'h0000_0000, "R1");
        look(32'h1234_5678, "R2");
        look(32'hFFFF_FFFC, "R2");

        // R3: fill, then hit next cycle; R10: result in the same cycle as lk_pc
        step(32'h0000_0100, 1'b1, 1'b1, 32'h0000_1040, 32'h0000_2000, "R3");
        look(32'h0000_1040, "R3");
        look(32'h0000_1040, "R10");

        // R4: not-taken resolves never allocate or modify
        step(32'h0000_0100, 1'b1, 1'b0, 32'h0000_5080, 32'h0000_9000, "R4");
        look(32'h0000_5080, "R4");
        step(32'h0000_0100, 1'b1, 1'b0, 32'h0000_1040, 32'h0000_7770, "R4");
        look(32'h0000_1040, "R4");

        // R8: rs_valid low blocks even a taken flag
        step(32'h0000_0100, 1'b0, 1'b1, 32'h0000_60C0, 32'h0000_ABC0, "R8");
        look(32'h0000_60C0, "R8");
        step(32'h0000_0100, 1'b0, 1'b1, 32'h0000_1040, 32'h0000_DDD0, "R8");
        look(32'h0000_1040, "R8");

        // R5: low two bits ignored; same slot, different tag misses
        look(32'h0000_1043, "R5");
        look(32'h0001_1040, "R5");

        // R6: conflicting fill evicts; retarget of the same branch
        step(32'h0000_0100, 1'b1, 1'b1, 32'h0001_1040, 32'h0000_3000, "R6");
        look(32'h0000_1040, "R6");
        look(32'h0001_1040, "R6");
        step(32'h0000_0100, 1'b1, 1'b1, 32'h0001_1040, 32'h0000_3400, "R6");
        look(32'h0001_1040, "R6");

        // R7: same-cycle write and lookup of one slot see old contents
        step(32'h0000_2204, 1'b1, 1'b1, 32'h0000_2204, 32'h0000_4440, "R7");
        look(32'h0000_2204, "R7");
        step(32'h0000_2204, 1'b1, 1'b1, 32'h0000_2204, 32'h0000_5550, "R7");
        look(32'h0000_2204, "R7");

        // R9: fill every slot, then read all back
        for (int i = 0; i < 64; i++) begin
            step(32'h0000_0000, 1'b1, 1'b1, 32'h0040_0000 + 32'(i * 4),
                 32'h8000_0000 + 32'(i * 16), "R9");
        end
        for (int i = 0; i < 64; i++) begin
            look(32'h0040_0000 + 32'(i * 4), "R9");
        end

        // R1: reset in mid-run empties a full table
        apply_reset();
        look(32'h0040_0000, "R1");
        look(32'h0040_00FC, "R1");
        look(32'h0001_1040, "R1");

        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule